// File: doc/BRIEF.md
# USB Device Interrupt Aggregator

This block collects the event indications of a full-speed USB device controller into one interrupt status word, masks each flag with its own enable bit and drives a single interrupt pin. Bus-level events (bus reset, resume, suspend, start-of-frame, pseudo start-of-frame, end-of-transfer and short end-of-transfer) are latched and cleared together when the status word is read. Endpoint completion flags, up to `NUM_EP` of them, are latched separately and each clears only on a pulse that marks a read of that endpoint's own status. A live bus-state bit is shown in the status word without latching.

A frame watchdog runs a timer of `TICKS_PER_MS` clock cycles, one millisecond of bus time. Each time the timer expires without a genuine start-of-frame, it raises a pseudo start-of-frame event. When `MISS_LIMIT` consecutive frames are missed, it also raises suspend and then stops. Its states are WD_IDLE (no frame seen yet), WD_LOCKED (a frame arrived, no misses), WD_MISSING (one or more misses) and WD_SUSPENDED (the miss limit was reached). A genuine start-of-frame moves any state to WD_LOCKED, reloads the timer and clears the miss count. A timer expiry moves WD_LOCKED or WD_MISSING to WD_MISSING, or to WD_SUSPENDED when it is the last allowed miss.

The output stage has its own state machine. OS_IDLE leaves the pin inactive. In level mode, OS_LEVEL follows the combined request and returns to OS_IDLE when the request drops. In pulse mode, a rising edge of the combined request moves the stage to OS_PULSE for `PULSE_LEN` cycles. It then goes to OS_HOLD until the request drops, or to OS_IDLE if the request has already dropped. A change of mode moves OS_LEVEL to OS_HOLD and OS_HOLD to OS_LEVEL. A configuration bit selects the pin polarity.

Top module: `usbd_irq_hub`

## Requirements
- R1: A read of the status word (address 0) clears the latched bus-event bits: bus reset (bit 0), resume (bit 1), suspend (bit 2), start-of-frame (bit 3), pseudo start-of-frame (bit 4), end-of-transfer (bit 5) and short end-of-transfer (bit 6).
- R2: The flag of endpoint n sits at status bit 8+n. It is set by `ev_ep[n]`, is unchanged by a status-word read and clears only on `ep_stat_rd[n]`.
- R3: Status bit 7 shows the `bus_live` input as it was in the read cycle and is never latched.
- R4: No pseudo start-of-frame is raised before the first start-of-frame. After one, a pseudo start-of-frame is raised each time `TICKS_PER_MS` cycles pass without a start-of-frame.
- R5: On the `MISS_LIMIT`-th consecutive miss, suspend is raised together with the pseudo start-of-frame, and the watchdog then raises nothing more until the next start-of-frame.
- R6: A genuine start-of-frame reloads the timer and clears the miss count.
- R7: The interrupt is active exactly when configuration bit 0 (global enable) is set and some status flag is set together with its enable bit. The pin follows one cycle after the flag.
- R8: Configuration bit 1 selects the polarity: 1 drives the pin high when active, 0 drives it low when active and high when idle.
- R9: With configuration bit 2 set, each rising edge of the combined request gives an active pulse of exactly `PULSE_LEN` cycles.
- R10: If an event and a clear fall in the same cycle, the event wins and the flag is set afterwards.
- R11: Reset clears all flags, the enable word and the configuration. The enable word (address 1, status bit positions) and the configuration (address 2, 3 bits) read back as written. Read data appears one cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 status, 1 enable, 2 config |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, valid the cycle after rd_en |
| ev_bus_rst | input | 1 | Bus reset event pulse |
| ev_resume | input | 1 | Resume event pulse |
| ev_suspend | input | 1 | Suspend detected elsewhere |
| ev_sof | input | 1 | Genuine start-of-frame pulse |
| ev_eot | input | 1 | End-of-transfer pulse |
| ev_eot_short | input | 1 | Short end-of-transfer pulse |
| ev_ep | input | NUM_EP | Endpoint completion pulses |
| ep_stat_rd | input | NUM_EP | Endpoint status read pulses |
| bus_live | input | 1 | Current bus state |
| irq_pin | output | 1 | Interrupt output |

## Verification
Two functions can act on the same flag in the same cycle: setting it from an event and clearing it by a read. The bench drives an end-of-transfer pulse in the same cycle as a status-word read. It then checks that the read returns the old value and that the next read shows the bit set. It does the same with an endpoint completion and that endpoint's status-read pulse, and expects the endpoint flag to survive.

// File: rtl/usbd_irq_pkg.sv
package usbd_irq_pkg;

    localparam int BIT_BUSRST = 0;
    localparam int BIT_RESUME = 1;
    localparam int BIT_SUSP   = 2;
    localparam int BIT_SOF    = 3;
    localparam int BIT_PSOF   = 4;
    localparam int BIT_EOT    = 5;
    localparam int BIT_EOTS   = 6;
    localparam int BIT_LIVE   = 7;
    localparam int EP_BASE    = 8;
    localparam int NUM_BUS_EV = 7;

    localparam int CFG_GEN   = 0;
    localparam int CFG_AHIGH = 1;
    localparam int CFG_PULSE = 2;
    localparam int CFG_W     = 3;

    typedef enum logic [1:0] {
        REG_STATUS = 2'd0,
        REG_ENABLE = 2'd1,
        REG_CONFIG = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        WD_IDLE,
        WD_LOCKED,
        WD_MISSING,
        WD_SUSPENDED
    } wd_state_e;

    typedef enum logic [1:0] {
        OS_IDLE,
        OS_LEVEL,
        OS_PULSE,
        OS_HOLD
    } out_state_e;

endpackage

// File: rtl/usbd_irq_flags.sv
module usbd_irq_flags
    import usbd_irq_pkg::*;
#(
    parameter int NUM_EP = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_BUS_EV-1:0] bus_set,
    input  logic                  bus_clr,
    input  logic [NUM_EP-1:0]     ep_set,
    input  logic [NUM_EP-1:0]     ep_clr,
    output logic [NUM_BUS_EV-1:0] bus_q,
    output logic [NUM_EP-1:0]     ep_q
);

    // Set has priority over clear in every flag (R10)
    for (genvar b = 0; b < NUM_BUS_EV; b++) begin : g_bus
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bus_q[b] <= 1'b0;
            end else begin
                bus_q[b] <= bus_set[b] | (bus_q[b] & ~bus_clr);
            end
        end
    end

    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ep_q[e] <= 1'b0;
            end else begin
                ep_q[e] <= ep_set[e] | (ep_q[e] & ~ep_clr[e]);
            end
        end
    end

endmodule

// File: rtl/usbd_irq_sofwd.sv
module usbd_irq_sofwd
    import usbd_irq_pkg::*;
#(
    parameter int TICKS_PER_MS = 12000,
    parameter int MISS_LIMIT   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sof,
    output logic psof_ev,
    output logic susp_ev
);

    localparam int CNT_W  = (TICKS_PER_MS > 2) ? $clog2(TICKS_PER_MS) : 1;
    localparam int MISS_W = $clog2(MISS_LIMIT + 1);
    localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(TICKS_PER_MS - 1);
    localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(MISS_LIMIT - 1);

    wd_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [MISS_W-1:0] miss_q;
    logic              running, expire, last_miss;

    assign running   = (state_q == WD_LOCKED) || (state_q == WD_MISSING);
    assign expire    = running && !sof && (cnt_q == CNT_LAST);
    assign last_miss = expire && (miss_q == MISS_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WD_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE: begin
                if (sof) state_d = WD_LOCKED;
            end
            WD_LOCKED: begin
                if (sof)            state_d = WD_LOCKED;
                else if (last_miss) state_d = WD_SUSPENDED;
                else if (expire)    state_d = WD_MISSING;
            end
            WD_MISSING: begin
                if (sof)            state_d = WD_LOCKED;
                else if (last_miss) state_d = WD_SUSPENDED;
            end
            WD_SUSPENDED: begin
                if (sof) state_d = WD_LOCKED;
            end
        endcase
    end

    // outputs
    always_comb begin
        psof_ev = expire;
        susp_ev = last_miss;
    end

    // timer and miss counter, reloaded by a genuine frame (R6)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            miss_q <= '0;
        end else if (sof) begin
            cnt_q  <= '0;
            miss_q <= '0;
        end else if (expire) begin
            cnt_q  <= '0;
            miss_q <= last_miss ? '0 : miss_q + 1'b1;
        end else if (running) begin
            cnt_q  <= cnt_q + 1'b1;
        end else begin
            cnt_q  <= '0;
        end
    end

endmodule

// File: rtl/usbd_irq_out.sv
module usbd_irq_out
    import usbd_irq_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic pulse_mode,
    input  logic active_high,
    output logic irq_pin
);

    localparam int PW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [PW-1:0] P_LAST = PW'(PULSE_LEN - 1);

    out_state_e    state_q, state_d;
    logic [PW-1:0] pcnt_q;
    logic          req_q, rise, active;

    assign rise = req && !req_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OS_IDLE: begin
                if (pulse_mode) begin
                    if (rise) state_d = OS_PULSE;
                end else if (req) begin
                    state_d = OS_LEVEL;
                end
            end
            OS_LEVEL: begin
                if (!req)           state_d = OS_IDLE;
                else if (pulse_mode) state_d = OS_HOLD;
            end
            OS_PULSE: begin
                if (pcnt_q == P_LAST) state_d = req ? OS_HOLD : OS_IDLE;
            end
            OS_HOLD: begin
                if (!req)            state_d = OS_IDLE;
                else if (!pulse_mode) state_d = OS_LEVEL;
            end
        endcase
    end

    // outputs
    always_comb begin
        active  = (state_q == OS_LEVEL) || (state_q == OS_PULSE);
        irq_pin = active_high ? active : !active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
            req_q  <= 1'b0;
        end else begin
            req_q  <= req;
            pcnt_q <= (state_q == OS_PULSE) ? pcnt_q + 1'b1 : '0;
        end
    end

endmodule

// File: rtl/usbd_irq_hub.sv
module usbd_irq_hub
    import usbd_irq_pkg::*;
#(
    parameter int NUM_EP       = 16,
    parameter int DATA_W       = 32,
    parameter int TICKS_PER_MS = 12000,
    parameter int MISS_LIMIT   = 3,
    parameter int PULSE_LEN    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              ev_bus_rst,
    input  logic              ev_resume,
    input  logic              ev_suspend,
    input  logic              ev_sof,
    input  logic              ev_eot,
    input  logic              ev_eot_short,
    input  logic [NUM_EP-1:0] ev_ep,
    input  logic [NUM_EP-1:0] ep_stat_rd,
    input  logic              bus_live,
    output logic              irq_pin
);

    localparam int ST_W = EP_BASE + NUM_EP;
    localparam logic [ST_W-1:0] LIVE_MASK = ST_W'(1) << BIT_LIVE;

    reg_sel_e              sel;
    logic                  stat_rd;
    logic [NUM_BUS_EV-1:0] bus_set, bus_q;
    logic [NUM_EP-1:0]     ep_q;
    logic                  wd_psof, wd_susp;
    logic [ST_W-1:0]       status_vec, en_q;
    logic [CFG_W-1:0]      cfg_q;
    logic [DATA_W-1:0]     rd_mux;
    logic                  req;

    assign sel     = reg_sel_e'(addr);
    assign stat_rd = rd_en && (sel == REG_STATUS);

    always_comb begin
        bus_set             = '0;
        bus_set[BIT_BUSRST] = ev_bus_rst;
        bus_set[BIT_RESUME] = ev_resume;
        bus_set[BIT_SUSP]   = ev_suspend | wd_susp;
        bus_set[BIT_SOF]    = ev_sof;
        bus_set[BIT_PSOF]   = wd_psof;
        bus_set[BIT_EOT]    = ev_eot;
        bus_set[BIT_EOTS]   = ev_eot_short;
    end

    usbd_irq_flags #(.NUM_EP(NUM_EP)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .bus_set (bus_set),
        .bus_clr (stat_rd),
        .ep_set  (ev_ep),
        .ep_clr  (ep_stat_rd),
        .bus_q   (bus_q),
        .ep_q    (ep_q)
    );

    usbd_irq_sofwd #(
        .TICKS_PER_MS (TICKS_PER_MS),
        .MISS_LIMIT   (MISS_LIMIT)
    ) u_sofwd (
        .clk     (clk),
        .rst_n   (rst_n),
        .sof     (ev_sof),
        .psof_ev (wd_psof),
        .susp_ev (wd_susp)
    );

    // live bus bit sits between the bus events and the endpoints
    assign status_vec = {ep_q, bus_live, bus_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            cfg_q <= '0;
        end else if (wr_en) begin
            if (sel == REG_ENABLE) en_q  <= wdata[ST_W-1:0];
            if (sel == REG_CONFIG) cfg_q <= wdata[CFG_W-1:0];
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (sel)
            REG_STATUS: rd_mux[ST_W-1:0]  = status_vec;
            REG_ENABLE: rd_mux[ST_W-1:0]  = en_q;
            REG_CONFIG: rd_mux[CFG_W-1:0] = cfg_q;
            REG_NONE:   rd_mux            = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
        end
    end

    assign req = cfg_q[CFG_GEN] && |(status_vec & en_q & ~LIVE_MASK);

    usbd_irq_out #(.PULSE_LEN(PULSE_LEN)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .pulse_mode  (cfg_q[CFG_PULSE]),
        .active_high (cfg_q[CFG_AHIGH]),
        .irq_pin     (irq_pin)
    );

endmodule

// File: rtl/usbd_irq_hub_chk.sv
module usbd_irq_hub_chk
    import usbd_irq_pkg::*;
#(
    parameter int NUM_EP = 16,
    parameter int DATA_W = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  rd_en,
    input logic [1:0]            addr,
    input logic                  ev_sof,
    input logic                  ev_eot,
    input logic [NUM_EP-1:0]     ev_ep,
    input logic [NUM_EP-1:0]     ep_stat_rd,
    input logic                  bus_live,
    input logic [DATA_W-1:0]     rdata,
    input logic [NUM_BUS_EV-1:0] bus_q,
    input logic [NUM_EP-1:0]     ep_q,
    input logic                  wd_psof,
    input logic                  wd_susp
);

    AST_BUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd0 && !ev_eot) |=> !bus_q[BIT_EOT]); // R1

    AST_EP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((ep_q & $past(ep_q & ~ep_stat_rd)) == $past(ep_q & ~ep_stat_rd))); // R2

    AST_LIVE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 2'd0) |=> (rdata[BIT_LIVE] == $past(bus_live))); // R3

    AST_SUSP_WITH_PSOF: assert property (@(posedge clk) disable iff (!rst_n)
        wd_susp |-> wd_psof); // R5

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_sof |=> bus_q[BIT_SOF]); // R10

    AST_EP_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ep != '0) |=> ((ep_q & $past(ev_ep)) == $past(ev_ep))); // R10

endmodule

bind usbd_irq_hub usbd_irq_hub_chk #(.NUM_EP(NUM_EP), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_usbd_irq_hub.sv
module test_usbd_irq_hub;

    localparam int CLK_PERIOD = 10;
    localparam int NEP   = 16;
    localparam int DW    = 32;
    localparam int TICKS = 50;

    // status bit positions as given in the requirements
    localparam logic [31:0] S_RST   = 32'h01;
    localparam logic [31:0] S_RES   = 32'h02;
    localparam logic [31:0] S_SUSP  = 32'h04;
    localparam logic [31:0] S_SOF   = 32'h08;
    localparam logic [31:0] S_PSOF  = 32'h10;
    localparam logic [31:0] S_EOT   = 32'h20;
    localparam logic [31:0] S_EOTS  = 32'h40;
    localparam logic [31:0] S_LIVE  = 32'h80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_en = 1'b0, wr_en = 1'b0;
    logic [1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic ev_bus_rst = 0, ev_resume = 0, ev_suspend = 0, ev_sof = 0, ev_eot = 0, ev_eot_short = 0;
    logic [NEP-1:0] ev_ep = '0, ep_stat_rd = '0;
    logic bus_live = 0;
    logic irq_pin;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        arm = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usbd_irq_hub #(
        .NUM_EP(NEP), .DATA_W(DW), .TICKS_PER_MS(TICKS), .MISS_LIMIT(3), .PULSE_LEN(4)
    ) i_usbd_irq_hub (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ev_bus_rst(ev_bus_rst), .ev_resume(ev_resume),
        .ev_suspend(ev_suspend), .ev_sof(ev_sof), .ev_eot(ev_eot),
        .ev_eot_short(ev_eot_short), .ev_ep(ev_ep), .ep_stat_rd(ep_stat_rd),
        .bus_live(bus_live), .irq_pin(irq_pin)
    );

    // monitor: scoreboard side of the read path
    always @(posedge clk) arm <= rd_en;

    always @(negedge clk) begin
        if (arm) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rdata !== e) begin
                errors++;
                $display("FAIL %s rdata=%h expected=%h", t, rdata, e);
            end
        end
    end

    function automatic logic [31:0] epb(input int n);
        return 32'h1 << (8 + n);
    endfunction

    // one stimulus cycle: bus events (status bit positions), endpoint events,
    // endpoint status reads and an optional status read with its expectation
    task automatic cyc(input logic [31:0] bus, input logic [NEP-1:0] ep,
                       input logic [NEP-1:0] eprd, input bit rd,
                       input logic [31:0] exp, input string tag);
        @(negedge clk);
        ev_bus_rst   = bus[0];
        ev_resume    = bus[1];
        ev_suspend   = bus[2];
        ev_sof       = bus[3];
        ev_eot       = bus[5];
        ev_eot_short = bus[6];
        ev_ep        = ep;
        ep_stat_rd   = eprd;
        if (rd) begin
            rd_en = 1'b1;
            addr  = 2'd0;
            exp_q.push_back(exp);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        {ev_bus_rst, ev_resume, ev_suspend, ev_sof, ev_eot, ev_eot_short} = '0;
        ev_ep = '0;
        ep_stat_rd = '0;
        rd_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1;
        addr  = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        @(negedge clk);
        checks++;
        if (irq_pin !== exp) begin
            errors++;
            $display("FAIL %s irq_pin=%b expected=%b", tag, irq_pin, exp);
        end
    endtask

    task automatic chk_pulse(input int exp, input string tag);
        int n = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (irq_pin === 1'b1) n++;
        end
        checks++;
        if (n != exp) begin
            errors++;
            $display("FAIL %s pulse_cycles=%0d expected=%0d", tag, n, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete");
            summary();
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;

        // R11 reset state; idle pin is high with active-low polarity
        chk_irq(1'b1, "R11 reset pin");
        rd(2'd0, 32'h0, "R11 reset status");
        rd(2'd1, 32'h0, "R11 reset enable");
        rd(2'd2, 32'h0, "R11 reset config");

        // R1 bus events latch and clear on status read
        cyc(S_RST | S_RES | S_SUSP | S_SOF | S_EOT | S_EOTS, '0, '0, 0, '0, "");
        rd(2'd0, S_RST | S_RES | S_SUSP | S_SOF | S_EOT | S_EOTS, "R1 latched");
        rd(2'd0, 32'h0, "R1 cleared");

        // R4 pseudo frames after the frame above; R5 suspend on third miss
        idle(30);
        rd(2'd0, 32'h0, "R4 no psof before period");
        idle(25);
        rd(2'd0, S_PSOF, "R4 first psof");
        idle(30);
        rd(2'd0, 32'h0, "R4 psof cleared");
        idle(30);
        rd(2'd0, S_PSOF, "R5 second miss no suspend");
        idle(40);
        rd(2'd0, S_PSOF | S_SUSP, "R5 third miss suspend");
        idle(120);
        rd(2'd0, 32'h0, "R5 watchdog halted");

        // R6 regular frames keep the watchdog quiet
        for (int i = 0; i < 5; i++) begin
            cyc(S_SOF, '0, '0, 0, '0, "");
            idle(38);
        end
        rd(2'd0, S_SOF, "R6 reload no psof");
        idle(70);
        rd(2'd0, S_PSOF, "R6 misses resume");
        cyc(S_SOF, '0, '0, 0, '0, "");
        idle(108);
        rd(2'd0, S_SOF | S_PSOF, "R6 miss count cleared");
        idle(50);
        rd(2'd0, S_PSOF | S_SUSP, "R5 suspend after reload");

        // R3 live bus bit
        bus_live = 1'b1;
        rd(2'd0, S_LIVE, "R3 live high");
        bus_live = 1'b0;
        rd(2'd0, 32'h0, "R3 live low");

        // R2 endpoint flags
        cyc('0, 16'h8008, '0, 0, '0, "");
        rd(2'd0, epb(3) | epb(15), "R2 ep set");
        rd(2'd0, epb(3) | epb(15), "R2 ep survive status read");
        cyc('0, '0, 16'h0008, 0, '0, "");
        rd(2'd0, epb(15), "R2 ep3 own clear");

        // R10 set wins over clear
        cyc(S_EOT, '0, '0, 1, epb(15), "R10 read old value");
        rd(2'd0, S_EOT | epb(15), "R10 eot survives read");
        cyc('0, 16'h0004, 16'h0004, 0, '0, "");
        rd(2'd0, epb(2) | epb(15), "R10 ep survives own clear");
        cyc('0, '0, 16'h8004, 0, '0, "");
        rd(2'd0, 32'h0, "R2 all ep cleared");

        // R11 register readback
        wr(2'd1, 32'h00A5_5A3C);
        rd(2'd1, 32'h00A5_5A3C, "R11 enable readback");
        wr(2'd2, 32'hFFFF_FFFD);
        rd(2'd2, 32'h0000_0005, "R11 config readback");

        // R7 level mode, active high
        wr(2'd1, epb(15));
        wr(2'd2, 32'h3);
        chk_irq(1'b0, "R7 no flag");
        cyc('0, 16'h8000, '0, 0, '0, "");
        idle(1);
        chk_irq(1'b1, "R7 enabled flag");
        wr(2'd1, 32'h0);
        idle(1);
        chk_irq(1'b0, "R7 masked flag");
        wr(2'd1, epb(15));
        wr(2'd2, 32'h2);
        idle(1);
        chk_irq(1'b0, "R7 global off");
        wr(2'd2, 32'h3);
        idle(1);
        chk_irq(1'b1, "R7 global on");

        // R8 polarity
        wr(2'd2, 32'h1);
        idle(1);
        chk_irq(1'b0, "R8 active low asserted");
        cyc('0, '0, 16'h8000, 0, '0, "");
        idle(1);
        chk_irq(1'b1, "R8 active low idle");

        // R9 pulse mode
        wr(2'd2, 32'h7);
        cyc('0, 16'h8000, '0, 0, '0, "");
        chk_pulse(4, "R9 first pulse");
        cyc('0, '0, 16'h8000, 0, '0, "");
        idle(2);
        cyc('0, 16'h8000, '0, 0, '0, "");
        chk_pulse(4, "R9 second pulse");

        idle(3);
        done = 1;
        summary();
    end

endmodule